// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. It holds the accumulator, a second-operand holding register that control loads separately, and a five-flag status register. On a cycle with `op_valid` high it applies the operation chosen by `op_sel` to the accumulator and the holding register. It writes the result back to the accumulator and updates the flags according to the operation class. A compare updates the flags only. Complement and the two rotates leave the sign, zero and parity flags as they were.

When no operation is issued, control can move a byte straight into the accumulator, and the flags stay unchanged. The flags are presented as one packed byte. Each flag has a fixed bit position and the unused positions are held at zero. All state updates on the rising clock edge, and the new accumulator and flag byte are visible in the cycle after the request.

Top module: `alu8_unit`

## Requirements
- R1: Synchronous active-high reset clears the accumulator, the holding register and all flags to zero.
- R2: With `op_valid` low, `acc_load` copies `acc_din` into the accumulator one cycle later and leaves the flags unchanged. While `op_valid` is high, `acc_load` is ignored. `tmp_load` always loads `tmp_din` into the holding register, and an operation issued in the same cycle uses the holding register's previous value.
- R3: Opcode 0 adds: accumulator plus holding register. CY is the carry out of bit 7 and AC is the carry from bit 3 into bit 4. For example, 9Bh plus A5h gives 40h with flag byte 11h.
- R4: Opcode 1 subtracts the holding register from the accumulator and writes the difference. Opcode 7 compares: it computes the same difference and sets the same flags, but leaves the accumulator unchanged. For both, CY is set exactly when a borrow occurs (accumulator < holding register, unsigned). AC is set when the low nibble of the accumulator is not below the low nibble of the holding register, which is the nibble carry of the two's-complement addition.
- R5: Opcode 2 increments and opcode 3 decrements the accumulator, and neither changes CY. On increment, AC is set when the old low nibble was Fh. On decrement, AC is set when the old low nibble was not 0h. Decrementing 01h gives 00h with Z set.
- R6: Opcodes 4, 5 and 6 write AND, OR and XOR of the two operands, and clear both CY and AC.
- R7: For opcodes 0 to 7, S takes bit 7 of the result, Z is set when the result is 00h, and P is set when the result has an even number of 1 bits.
- R8: The flag byte carries S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0. Bits 5, 3 and 1 always read 0.
- R9: Opcode 8 writes the bitwise complement of the accumulator and leaves every flag unchanged.
- R10: Opcode 9 rotates the accumulator left by one bit, with bit 7 moving into bit 0, and copies the old bit 7 into CY. Opcode 10 rotates right by one bit, with bit 0 moving into bit 7, and copies the old bit 0 into CY. The other flags are unchanged.
- R11: Opcodes 11 to 15 change neither the accumulator nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_load | input | 1 | Move `acc_din` into the accumulator (ignored during an operation) |
| acc_din | input | 8 | Byte to move into the accumulator |
| tmp_load | input | 1 | Load `tmp_din` into the second-operand register |
| tmp_din | input | 8 | Byte for the second-operand register |
| op_valid | input | 1 | Execute the operation in `op_sel` this cycle |
| op_sel | input | 4 | Operation code, 0 to 10 defined |
| acc_q | output | 8 | Accumulator contents |
| flags_q | output | 8 | Packed flag byte |

## Verification
Two overlaps can occur in one cycle. The first is an operation issued in the same cycle as a holding-register load, which must use the old operand. The second is an operation issued in the same cycle as an accumulator move, which must discard the move. The random stream raises `acc_load`, `tmp_load` and `op_valid` independently, so both overlaps occur often. Directed steps also force each overlap with operand values whose outcome differs visibly. Each step is judged against a bench model that applies the operation with the pre-edge operands, drops a move issued with an operation, and only then applies a holding-register load.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int NW = DW / 2;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMP = 4'd7,
        OP_NOT = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic hcy;
        logic par;
        logic cy;
    } alu_flags_t;

    function automatic logic even_ones(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [7:0] flags_to_byte(input alu_flags_t f);
        return {f.sgn, f.zro, 1'b0, f.hcy, 1'b0, f.par, 1'b0, f.cy};
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          hcout
);
    localparam int HW = DW - NW;

    logic [NW:0] lo;
    logic [HW:0] hi;

    assign lo    = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
    assign hi    = {1'b0, a[DW-1:NW]} + {1'b0, b[DW-1:NW]} + {{HW{1'b0}}, lo[NW]};
    assign sum   = {hi[HW-1:0], lo[NW-1:0]};
    assign cout  = hi[HW];
    assign hcout = lo[NW];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_flags_t    fin,
    output logic [DW-1:0] res,
    output alu_flags_t    fout,
    output logic          acc_we,
    output logic          flg_we
);
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] sum;
    logic          cout;
    logic          hcout;
    logic          szp_upd;

    // operand shaping: subtraction as a + ~b + 1, decrement as a + all-ones
    always_comb begin
        add_b   = b;
        add_cin = 1'b0;
        case (op)
            OP_SUB, OP_CMP: begin add_b = ~b;          add_cin = 1'b1; end
            OP_INC:         begin add_b = '0;          add_cin = 1'b1; end
            OP_DEC:         begin add_b = '1;          add_cin = 1'b0; end
            default:        begin add_b = b;           add_cin = 1'b0; end
        endcase
    end

    alu8_addsub u_addsub (
        .a     (a),
        .b     (add_b),
        .cin   (add_cin),
        .sum   (sum),
        .cout  (cout),
        .hcout (hcout)
    );

    always_comb begin
        res     = a;
        fout    = fin;
        acc_we  = 1'b0;
        flg_we  = 1'b0;
        szp_upd = 1'b0;
        case (op)
            OP_ADD: begin
                res = sum; acc_we = 1'b1; flg_we = 1'b1; szp_upd = 1'b1;
                fout.cy = cout; fout.hcy = hcout;
            end
            OP_SUB, OP_CMP: begin
                res = sum; acc_we = (op == OP_SUB); flg_we = 1'b1; szp_upd = 1'b1;
                fout.cy = ~cout; fout.hcy = hcout;
            end
            OP_INC, OP_DEC: begin
                res = sum; acc_we = 1'b1; flg_we = 1'b1; szp_upd = 1'b1;
                fout.hcy = hcout;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res = (op == OP_AND) ? (a & b) : (op == OP_OR) ? (a | b) : (a ^ b);
                acc_we = 1'b1; flg_we = 1'b1; szp_upd = 1'b1;
                fout.cy = 1'b0; fout.hcy = 1'b0;
            end
            OP_NOT: begin
                res = ~a; acc_we = 1'b1;
            end
            OP_ROL: begin
                res = {a[DW-2:0], a[DW-1]}; acc_we = 1'b1; flg_we = 1'b1;
                fout.cy = a[DW-1];
            end
            OP_ROR: begin
                res = {a[0], a[DW-1:1]}; acc_we = 1'b1; flg_we = 1'b1;
                fout.cy = a[0];
            end
            default: begin
                res = a;
            end
        endcase
        if (szp_upd) begin
            fout.sgn = res[DW-1];
            fout.zro = (res == '0);
            fout.par = even_ones(res);
        end
    end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_load,
    input  logic [DW-1:0] acc_din,
    input  logic          tmp_load,
    input  logic [DW-1:0] tmp_din,
    input  logic          op_valid,
    input  logic [OPW-1:0] op_sel,
    output logic [DW-1:0] acc_q,
    output logic [7:0]    flags_q
);
    logic [DW-1:0] acc_r;
    logic [DW-1:0] tmp_r;
    alu_flags_t    flg_r;
    alu_op_e       op;
    logic [DW-1:0] res;
    alu_flags_t    fnext;
    logic          acc_we;
    logic          flg_we;

    assign op = alu_op_e'(op_sel);

    alu8_core u_core (
        .op     (op),
        .a      (acc_r),
        .b      (tmp_r),
        .fin    (flg_r),
        .res    (res),
        .fout   (fnext),
        .acc_we (acc_we),
        .flg_we (flg_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r <= '0;
            tmp_r <= '0;
            flg_r <= '0;
        end else begin
            if (op_valid) begin
                if (acc_we) acc_r <= res;
                if (flg_we) flg_r <= fnext;
            end else if (acc_load) begin
                acc_r <= acc_din;
            end
            if (tmp_load) tmp_r <= tmp_din;
        end
    end

    assign acc_q   = acc_r;
    assign flags_q = flags_to_byte(flg_r);

    // R2
    move_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && acc_load) |=> (acc_q == $past(acc_din)) && $stable(flags_q));

    // R4
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 4'd7) |=> $stable(acc_q));

    // R5
    incdec_keeps_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == 4'd2 || op_sel == 4'd3)) |=> (flags_q[0] == $past(flags_q[0])));

    // R6
    logic_clears_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel >= 4'd4 && op_sel <= 4'd6) |=> (!flags_q[0] && !flags_q[4]));

    // R7
    sz_track_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel <= 4'd6) |=> (flags_q[6] == (acc_q == '0)) && (flags_q[7] == acc_q[DW-1]));

    // R10
    rol_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 4'd9) |=> (flags_q[0] == $past(acc_q[DW-1])) &&
                                         (acc_q == {$past(acc_q[DW-2:0]), $past(acc_q[DW-1])}));

    // R11
    reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel > 4'd10) |=> $stable(acc_q) && $stable(flags_q));
endmodule

// File: tb/tb_alu8_unit.sv
module tb_alu8_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_load = 1'b0;
    logic [7:0] acc_din = 8'h00;
    logic       tmp_load = 1'b0;
    logic [7:0] tmp_din = 8'h00;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] acc_q;
    logic [7:0] flags_q;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_acc = 8'h00;
    logic [7:0] m_tmp = 8'h00;
    logic [7:0] m_flg = 8'h00;

    always #4 clk = ~clk;

    alu8_unit dut (
        .clk(clk), .rst(rst), .acc_load(acc_load), .acc_din(acc_din),
        .tmp_load(tmp_load), .tmp_din(tmp_din), .op_valid(op_valid),
        .op_sel(op_sel), .acc_q(acc_q), .flags_q(flags_q)
    );

    // returns {new accumulator, new flag byte}
    function automatic logic [15:0] model_op(input int op, input logic [7:0] a,
                                             input logic [7:0] t, input logic [7:0] f);
        int r;
        logic [7:0] res;
        bit s = f[7], z = f[6], ac = f[4], p = f[2], cy = f[0];
        case (op)
            0:       begin r = int'(a) + int'(t); cy = (r > 255); ac = ((a % 16) + (t % 16)) > 15; end
            1, 7:    begin r = int'(a) - int'(t); cy = (a < t); ac = (a % 16) >= (t % 16); end
            2:       begin r = int'(a) + 1; ac = (a % 16) == 15; end
            3:       begin r = int'(a) - 1; ac = (a % 16) != 0; end
            4:       begin r = int'(a & t); cy = 0; ac = 0; end
            5:       begin r = int'(a | t); cy = 0; ac = 0; end
            6:       begin r = int'(a ^ t); cy = 0; ac = 0; end
            8:       r = int'(~a);
            9:       begin r = int'({a[6:0], a[7]}); cy = a[7]; end
            10:      begin r = int'({a[0], a[7:1]}); cy = a[0]; end
            default: r = int'(a);
        endcase
        res = r[7:0];
        if (op <= 7) begin
            s = res[7];
            z = (res == 8'h00);
            p = ($countones(res) % 2) == 0;
        end
        if (op == 7 || op > 10) res = a;
        return {res, s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
    endfunction

    function automatic string tag_of(input bit ov, input int op);
        if (!ov) return "R2";
        case (op)
            0: return "R3";
            1, 7: return "R4";
            2, 3: return "R5";
            4, 5, 6: return "R6";
            8: return "R9";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check8(input string req, input string what, input logic [7:0] got,
                          input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %02h expected %02h", req, what, got, exp);
        end
    endtask

    // drive at negedge, model the edge, sample at the following negedge
    task automatic step(input bit al, input logic [7:0] ad, input bit tl, input logic [7:0] td,
                        input bit ov, input int op, input string req);
        logic [15:0] r;
        acc_load = al; acc_din = ad; tmp_load = tl; tmp_din = td;
        op_valid = ov; op_sel = 4'(op);
        if (ov) begin
            r = model_op(op, m_acc, m_tmp, m_flg);
            m_acc = r[15:8];
            m_flg = r[7:0];
        end else if (al) begin
            m_acc = ad;
        end
        if (tl) m_tmp = td;
        @(posedge clk);
        @(negedge clk);
        check8(req, "acc", acc_q, m_acc);
        check8(req, "flags", flags_q, m_flg);
        acc_load = 1'b0; tmp_load = 1'b0; op_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check8("R1", "acc", acc_q, 8'h00);
        check8("R1", "flags", flags_q, 8'h00);
        // R1: holding register reset, seen through OR with zero accumulator
        step(0, 8'h00, 0, 8'h00, 1, 5, "R1");
        // R3 R8: 9Bh + A5h
        step(1, 8'h9B, 1, 8'hA5, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 0, "R3");
        check8("R3", "acc literal", acc_q, 8'h40);
        check8("R8", "flag byte literal", flags_q, 8'h11);
        // R2: move issued with an operation is dropped
        step(1, 8'h77, 0, 8'h00, 1, 2, "R2");
        // R2: holding load in the same cycle as an operation uses the old operand
        step(0, 8'h00, 1, 8'h0F, 1, 1, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 4, "R6");
        // R5: decrement 01h to zero
        step(1, 8'h01, 0, 8'h00, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 3, "R5");
        check8("R5", "dec zero", flags_q & 8'h40, 8'h40);
        // R4: borrow and compare equal
        step(1, 8'h10, 1, 8'h20, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 1, "R4");
        step(1, 8'h20, 0, 8'h00, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 7, "R4");
        check8("R7", "cmp equal Z", flags_q & 8'h40, 8'h40);
        // R5: increment FFh keeps carry
        step(1, 8'hFF, 0, 8'h00, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 2, "R5");
        // R10 R9 R11
        step(1, 8'h81, 0, 8'h00, 0, 0, "R2");
        step(0, 8'h00, 0, 8'h00, 1, 9, "R10");
        step(0, 8'h00, 0, 8'h00, 1, 10, "R10");
        step(0, 8'h00, 0, 8'h00, 1, 8, "R9");
        step(0, 8'h00, 0, 8'h00, 1, 13, "R11");
        // R7 R8: random mix
        for (int i = 0; i < 600; i++) begin
            bit al = ($urandom % 3) == 0;
            bit tl = ($urandom % 2) == 0;
            bit ov = ($urandom % 4) != 0;
            int op = int'($urandom % 16);
            step(al, 8'($urandom), tl, 8'($urandom), ov, op, tag_of(ov, op));
        end
        summary();
    end
endmodule